// File: doc/BRIEF.md
# Serial Register Readback Controller

This block sits behind a 24-bit serial input port and takes in one word per frame. A frame starts when the active-low frame select falls and ends when it rises. Each complete word is decoded as either a write to a small register file or a read request. The file holds a data, an offset and a gain value for every channel. A write places the 14-bit payload into the register it selects.

A read request does not answer in its own frame. The controller latches the selected register together with the request's upper ten header bits. It shifts that 24-bit response out on the serial output during the next frame, whatever that frame carries. An all-zero word does nothing else, so it is the usual way to fetch the response.

Serial clock, frame select and input data are sampled by the system clock. The serial clock may idle either high or low between frames. Each response bit changes after a serial clock rising edge and is meant to be captured on the following falling edge. The most significant response bit is driven as soon as the frame select falls.

Top module: `sreg_readback`

## Requirements
- R1: A complete frame whose bit 22 is 1 is a read request. The next frame that begins then shifts out, MSB first, the request's bits 23..14 followed by the 14-bit value of the selected register, read at the end of the request frame.
- R2: The channel index is bits 19..16 and the register select is bits 15..14. Select 11 picks data, 10 picks offset and 01 picks gain, so request 0x404000 returns 0x407FFF after reset.
- R3: A complete frame with bit 22 at 0 and a nonzero select writes bits 13..0 into the selected register of the indexed channel when the frame ends.
- R4: A write-type word with select 00, including the all-zero word, changes no register.
- R5: A frame that ends after fewer than 24 serial clock falling edges is discarded. It writes nothing and makes no new request, and a response still pending is sent again in the following frame.
- R6: Serial clock edges after the 24th falling edge of a frame are ignored. The frame still counts as complete and uses its first 24 bits.
- R7: The serial output changes only when the frame select falls or after a rising serial clock edge that follows a sampled bit. It presents bit 23 of the response from the falling frame select, whether the serial clock idles high or low.
- R8: After reset, every data register is 0, every offset register is 0x2000 and every gain register is 0x3FFF.
- R9: A channel index at or above the channel count reads as 0, and a write to it changes no register.
- R10: A read request sent in the frame that carries an earlier response replaces it, so consecutive read frames each return the previous request's register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock; input data is captured on its falling edge |
| syncN | input | 1 | Active-low frame select |
| din | input | 1 | Serial input data, MSB first |
| sdo | output | 1 | Serial response data, MSB first |

## Verification
Directed frames first read every register kind right after reset. They then check the fixed example request, a write followed by a read, a select-00 word and an out-of-range channel, which between them separate the register-select decoding from the channel decoding. Truncated frames and frames with extra serial clocks show whether the bit counter bounds a frame correctly. They also show whether a pending response survives a bad frame. A constrained random run then mixes reads, writes, random header bits and both serial clock idle levels. It is compared against a bench model of the register file and the one-frame response delay, so any error in the echoed header bits or in the timing of the first bit shows up.

// File: rtl/sreg_rb_pkg.sv
package sreg_rb_pkg;
  localparam int FRAME_BITS = 24;
  localparam int VAL_W      = 14;
  localparam int ADDR_W     = 4;
  localparam int RW_BIT     = 22;
  localparam int ADDR_LSB   = 16;
  localparam int SEL_LSB    = 14;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

  typedef enum logic [1:0] {
    SEL_NONE   = 2'b00,
    SEL_GAIN   = 2'b01,
    SEL_OFFSET = 2'b10,
    SEL_DATA   = 2'b11
  } regSel_e;

  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic frameStart;
    logic sampleBit;
    logic shiftOut;
    logic commit;
  } rbStrobe_t;
endpackage

// File: rtl/sreg_rb_ctrl.sv
module sreg_rb_ctrl
  import sreg_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             syncN,
  output rbStrobe_t        st,
  output logic [CNT_W-1:0] bitCnt
);
  logic sclkQ, sclkQ2, syncQ, syncQ2;
  logic frameFall, frameRise, sclkFall, sclkRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ  <= 1'b1;
      sclkQ2 <= 1'b1;
      syncQ  <= 1'b1;
      syncQ2 <= 1'b1;
    end else begin
      sclkQ  <= sclk;
      sclkQ2 <= sclkQ;
      syncQ  <= syncN;
      syncQ2 <= syncQ;
    end
  end

  assign frameFall = syncQ2 && !syncQ;
  assign frameRise = !syncQ2 && syncQ;
  assign sclkFall  = sclkQ2 && !sclkQ && !syncQ;
  assign sclkRise  = !sclkQ2 && sclkQ && !syncQ;

  always_comb begin
    st            = '0;
    st.frameStart = frameFall;
    st.sampleBit  = sclkFall && !frameFall && (bitCnt < FULL_CNT);
    st.shiftOut   = sclkRise && !frameFall && (bitCnt != '0) && (bitCnt < FULL_CNT);
    st.commit     = frameRise && (bitCnt == FULL_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            bitCnt <= '0;
    else if (frameFall)   bitCnt <= '0;
    else if (st.sampleBit) bitCnt <= bitCnt + 1'b1;
  end
endmodule

// File: rtl/sreg_rb_dp.sv
module sreg_rb_dp
  import sreg_rb_pkg::*;
#(
  parameter int               CHANNELS   = 8,
  parameter logic [VAL_W-1:0] DATA_RST   = 14'h0000,
  parameter logic [VAL_W-1:0] OFFSET_RST = 14'h2000,
  parameter logic [VAL_W-1:0] GAIN_RST   = 14'h3FFF
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      din,
  input  rbStrobe_t st,
  output logic      sdo,
  output logic      readPending
);
  logic                  dinQ;
  logic [FRAME_BITS-1:0] rxWord, txWord, respWord;
  logic                  reqRead;
  logic [ADDR_W-1:0]     reqCh;
  regSel_e               reqSel;
  logic [VAL_W-1:0]      reqVal, readValue;
  logic [VAL_W-1:0]      dataR [CHANNELS];
  logic [VAL_W-1:0]      offR  [CHANNELS];
  logic [VAL_W-1:0]      gainR [CHANNELS];

  assign reqRead = rxWord[RW_BIT];
  assign reqCh   = rxWord[ADDR_LSB +: ADDR_W];
  assign reqSel  = regSel_e'(rxWord[SEL_LSB +: 2]);
  assign reqVal  = rxWord[VAL_W-1:0];

  for (genvar g = 0; g < CHANNELS; g++) begin : gChan
    logic chWrite;
    assign chWrite = st.commit && !reqRead && (reqCh == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataR[g] <= DATA_RST;
        offR[g]  <= OFFSET_RST;
        gainR[g] <= GAIN_RST;
      end else if (chWrite) begin
        case (reqSel)
          SEL_DATA:   dataR[g] <= reqVal;
          SEL_OFFSET: offR[g]  <= reqVal;
          SEL_GAIN:   gainR[g] <= reqVal;
          default:    ;
        endcase
      end
    end
  end

  always_comb begin
    readValue = '0;
    for (int i = 0; i < CHANNELS; i++) begin
      if (reqCh == ADDR_W'(i)) begin
        case (reqSel)
          SEL_DATA:   readValue = dataR[i];
          SEL_OFFSET: readValue = offR[i];
          SEL_GAIN:   readValue = gainR[i];
          default:    readValue = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dinQ        <= 1'b0;
      rxWord      <= '0;
      txWord      <= '0;
      respWord    <= '0;
      readPending <= 1'b0;
    end else begin
      dinQ <= din;
      if (st.sampleBit) rxWord <= {rxWord[FRAME_BITS-2:0], dinQ};
      if (st.commit) begin
        readPending <= reqRead;
        if (reqRead) respWord <= {rxWord[FRAME_BITS-1:VAL_W], readValue};
      end
      if (st.frameStart)    txWord <= readPending ? respWord : '0;
      else if (st.shiftOut) txWord <= {txWord[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign sdo = txWord[FRAME_BITS-1];
endmodule

// File: rtl/sreg_readback.sv
module sreg_readback
  import sreg_rb_pkg::*;
#(
  parameter int CHANNELS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic syncN,
  input  logic din,
  output logic sdo
);
  rbStrobe_t        st;
  logic [CNT_W-1:0] bitCnt;
  logic             readPending;

  sreg_rb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .syncN(syncN),
    .st(st), .bitCnt(bitCnt)
  );

  sreg_rb_dp #(.CHANNELS(CHANNELS)) u_dp (
    .clk(clk), .rstN(rstN), .din(din), .st(st),
    .sdo(sdo), .readPending(readPending)
  );
endmodule

// File: rtl/sreg_rb_checker.sv
module sreg_rb_checker
  import sreg_rb_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             syncN,
  input logic             sdo,
  input rbStrobe_t        st,
  input logic [CNT_W-1:0] bitCnt,
  input logic             readPending
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(st)) else $error("strobes overlap"); // R7

  AST_CNT_HOLDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == FULL_CNT) && !st.frameStart |=> (bitCnt == FULL_CNT)) else $error("count moved past full"); // R6

  AST_SDO_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdo) |-> $past(st.frameStart || st.shiftOut)) else $error("sdo moved without strobe"); // R7

  AST_SDO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    syncN && $past(syncN) && $past(syncN, 2) && $past(syncN, 3) |-> $stable(sdo)) else $error("sdo moved outside frame"); // R7

  AST_PENDING_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readPending) |-> $past(st.commit)) else $error("read latched without full frame"); // R1
endmodule

bind sreg_readback sreg_rb_checker u_chk (
  .clk(clk), .rstN(rstN), .syncN(syncN), .sdo(sdo),
  .st(st), .bitCnt(bitCnt), .readPending(readPending)
);

// File: tb/sreg_readback_bench.sv
module sreg_readback_bench;
  localparam int NCH = 8;
  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b1, syncN = 1'b1, din = 1'b0;
  logic sdo;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [13:0] mData [NCH];
  logic [13:0] mOff  [NCH];
  logic [13:0] mGain [NCH];
  bit          pendV = 1'b0;
  logic [23:0] pendW = '0;
  string       pendTag = "";

  sreg_readback #(.CHANNELS(NCH)) u_sreg_readback (
    .clk(clk), .rstN(rstN), .sclk(sclk), .syncN(syncN), .din(din), .sdo(sdo)
  );

  always #5 clk = ~clk;

  function automatic logic [23:0] mk(bit rw, int ch, logic [1:0] sel, logic [13:0] val);
    return {1'b0, rw, 2'b00, 4'(ch), sel, val};
  endfunction

  function automatic logic [13:0] modelRead(int ch, logic [1:0] sel);
    if (ch >= NCH) return 14'h0;
    case (sel)
      2'b11: return mData[ch];
      2'b10: return mOff[ch];
      2'b01: return mGain[ch];
      default: return 14'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
    end
  endtask

  // one frame; compares the shifted-out response when one is owed
  task automatic doFrame(logic [23:0] w, int nbits, bit idleHigh, string tag);
    logic [23:0] resp = '0;
    bit          owed = pendV;
    logic [23:0] exp  = pendW;
    string       expTag = pendTag;
    int          ch = int'(w[19:16]);
    sclk = idleHigh;
    #50 syncN = 1'b0;
    #60;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      #40;
      if (i < 24) begin
        resp[23-i] = sdo;
        din = w[23-i];
      end else din = 1'($urandom);
      #20 sclk = 1'b0;
      #40;
    end
    #20 sclk = idleHigh;
    #40 syncN = 1'b1;
    #60;
    if (owed && nbits >= 24) check(expTag, resp, exp);
    if (nbits >= 24) begin
      if (w[22]) begin
        pendV = 1'b1;
        pendW = {w[23:14], modelRead(ch, w[15:14])};
        pendTag = tag;
      end else begin
        pendV = 1'b0;
        if (ch < NCH) begin
          case (w[15:14])
            2'b11: mData[ch] = w[13:0];
            2'b10: mOff[ch]  = w[13:0];
            2'b01: mGain[ch] = w[13:0];
            default: ;
          endcase
        end
      end
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NCH; i++) begin
      mData[i] = 14'h0000; mOff[i] = 14'h2000; mGain[i] = 14'h3FFF;
    end
    #100 rstN = 1'b1;
    #50;
    check("R8 idle sdo", {23'h0, sdo}, 24'h0);
    // R8 reset values of every register kind
    doFrame(mk(1, 0, 2'b11, 0), 24, 1, "R8 data reset");
    doFrame(mk(1, 0, 2'b10, 0), 24, 1, "R8 offset reset");
    doFrame(mk(1, 7, 2'b01, 0), 24, 1, "R8 gain reset");
    // R2 fixed request 0x404xxx reads gain of channel 0
    doFrame(24'h404ABC, 24, 1, "R2 gain ch0");
    check("R2 header", pendW, 24'h407FFF);
    doFrame(24'h000000, 24, 1, "R4 nop");
    // R3 write then read
    doFrame(mk(0, 3, 2'b11, 14'h1234), 24, 1, "R3 write");
    doFrame(mk(1, 3, 2'b11, 0), 24, 1, "R3 data readback");
    // R4 select 00 write does nothing
    doFrame(mk(0, 3, 2'b00, 14'h0BAD), 24, 1, "R4 sel00");
    doFrame(mk(1, 3, 2'b11, 0), 24, 1, "R4 data unchanged");
    // R5 short frame is discarded, pending response survives
    doFrame(mk(0, 3, 2'b11, 14'h2222), 15, 1, "R5 short write");
    doFrame(mk(1, 3, 2'b11, 0), 24, 1, "R5 no write");
    doFrame(mk(1, 5, 2'b10, 0), 24, 1, "R5 pending kept");
    doFrame(mk(1, 1, 2'b11, 0), 9, 1, "R5 short read");
    doFrame(24'h000000, 24, 1, "R4 nop");
    // R6 extra clocks ignored
    doFrame(mk(0, 2, 2'b10, 14'h0155), 29, 1, "R6 extra clocks");
    doFrame(mk(1, 2, 2'b10, 0), 24, 1, "R6 offset readback");
    // R9 out-of-range channel
    doFrame(mk(0, 12, 2'b01, 14'h0777), 24, 1, "R9 write oob");
    doFrame(mk(1, 12, 2'b01, 0), 24, 1, "R9 read oob");
    doFrame(mk(1, 4, 2'b01, 0), 24, 1, "R9 ch4 untouched");
    // R10 back-to-back reads
    doFrame(mk(1, 6, 2'b11, 0), 24, 1, "R10 read a");
    doFrame(mk(1, 6, 2'b10, 0), 24, 1, "R10 read b");
    doFrame(mk(1, 3, 2'b11, 0), 24, 1, "R10 read c");
    // R7 serial clock idling low
    doFrame(mk(0, 1, 2'b01, 14'h2A5A), 24, 0, "R7 write idle low");
    doFrame(mk(1, 1, 2'b01, 0), 24, 0, "R7 idle low read");
    doFrame(24'h000000, 24, 1, "R7 idle high fetch");
    // R1 random mix
    for (int n = 0; n < 120; n++) begin
      logic [23:0] w;
      int nb;
      w = mk(1'($urandom), $urandom_range(0, 9), 2'($urandom), 14'($urandom));
      w[23] = 1'($urandom);
      w[21:20] = 2'($urandom);
      case ($urandom_range(0, 7))
        0: nb = $urandom_range(4, 23);
        1: nb = $urandom_range(25, 30);
        default: nb = 24;
      endcase
      doFrame(w, nb, 1'($urandom), "R1 random");
    end
    doFrame(24'h000000, 24, 1, "R1 flush");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule